// File: doc/BRIEF.md
# CPU-Space Register Decoder with Breakpoint Acknowledge

This block watches a processor bus for cycles whose function code marks them as CPU space and turns them into register selects. No outside address logic is needed. A cycle is recognised only when these fields line up:

- the function code,
- a four-bit cycle-type field,
- a coprocessor identifier,
- a block of address lines that must be zero.

A coprocessor cycle for identifier 0 selects one of eleven interface registers. An access-level cycle selects one of four access-level registers.

A breakpoint acknowledge cycle is answered from a bank of eight breakpoint pairs. Each pair holds a 16-bit replacement opcode and a control word with an enable bit and a count.

- An enabled breakpoint with a count of zero returns its opcode.
- An enabled breakpoint with a non-zero count steps the count down and returns an illegal-instruction response.
- A disabled breakpoint gets a bus-error response.

The breakpoint registers are loaded through a separate configuration write port.

Every response is registered. It appears as a single-cycle pulse in the clock cycle after the bus cycle is presented.

Top module: `cpu_space_decoder`

## Requirements
- R1: A cycle whose function code is not 7 gives no response: rsp_valid, cir_sel and alc_sel stay 0. It also leaves every breakpoint count unchanged.
- R2: A cycle is a coprocessor cycle when fc=7, addr[19:16]=2, addr[15:13]=0, addr[12:5]=0 and the word index addr[4:1] is below 11. One cycle later it gives rsp_valid=1, rsp_kind=0 (register select) and cir_sel with only bit [word index] set.
- R3: A coprocessor cycle whose identifier addr[15:13] is non-zero gives no response.
- R4: A coprocessor cycle whose word index is 11 to 15 gives no response.
- R5: An access-level cycle has fc=7, addr[19:16]=1 and addr[12:5]=0. With a word index below 4, one cycle later it gives rsp_valid=1, rsp_kind=0 and alc_sel bit [index] set. An index of 4 or more gives no response.
- R6: A breakpoint cycle has fc=7, addr[19:16]=0 and addr[12:5]=0, and uses breakpoint addr[4:2]. If that breakpoint is enabled with count 0, one cycle later it gives rsp_valid=1, rsp_kind=1 and rsp_data equal to the breakpoint's opcode. The count stays 0.
- R7: A breakpoint cycle on an enabled breakpoint with a non-zero count gives rsp_kind=2 and rsp_data=0, and lowers the count by one. Repeated cycles therefore give count-many illegal responses and then the opcode.
- R8: A breakpoint cycle on a disabled breakpoint gives rsp_kind=3 (bus error) and rsp_data=0. The breakpoint's state is not changed.
- R9: A CPU-space cycle whose type field is 3 to 15, or whose addr[12:5] is non-zero, gives no response.
- R10: After reset all outputs are 0, and every breakpoint is disabled with count 0 and opcode 0.
- R11: A configuration write with cfg_ctrl=0 loads the opcode of breakpoint cfg_idx from cfg_wdata. With cfg_ctrl=1 it loads the enable from cfg_wdata[15] and the count from cfg_wdata[7:0]. A breakpoint cycle in the same clock is answered from the old state, and the written value replaces the count step.
- R12: rsp_valid is high only in the cycle right after a recognised cycle. Back-to-back cycles give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| fc | input | 3 | Function code of the cycle |
| addr | input | 20 | Low logical address lines |
| cfg_we | input | 1 | Breakpoint configuration write strobe |
| cfg_ctrl | input | 1 | 1 selects the control word, 0 selects the opcode |
| cfg_idx | input | 3 | Breakpoint number to write |
| cfg_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_kind | output | 2 | 0 select, 1 opcode, 2 illegal, 3 bus error |
| rsp_data | output | 16 | Replacement opcode when rsp_kind=1 |
| cir_sel | output | 11 | One-hot interface register select |
| alc_sel | output | 4 | One-hot access-level register select |

## Verification
Every response is due exactly one clock after its cycle is presented. Inputs are driven on the falling edge, and the bench compares the outputs on the next falling edge against a model that advanced one step on the earlier stimulus.

A count step or a configuration write only shows at the next acknowledge of the same breakpoint, so the bench checks them through the kind returned by a later cycle. Cycles that should be ignored are followed by a breakpoint acknowledge, which shows that no count was consumed.

// File: rtl/cpu_space_pkg.sv
package cpu_space_pkg;

    localparam logic [2:0] FC_CPU     = 3'd7;
    localparam logic [3:0] TYPE_BKPT  = 4'd0;
    localparam logic [3:0] TYPE_ALC   = 4'd1;
    localparam logic [3:0] TYPE_COPRO = 4'd2;
    localparam logic [2:0] COPRO_ID   = 3'd0;

    typedef enum logic [1:0] {
        RSP_REGSEL  = 2'd0,
        RSP_OPCODE  = 2'd1,
        RSP_ILLEGAL = 2'd2,
        RSP_BUSERR  = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic       is_copro;
        logic       is_alc;
        logic       is_bkpt;
        logic [3:0] word_idx;
        logic [2:0] bkpt_idx;
    } dec_t;

endpackage

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
    import cpu_space_pkg::*;
#(
    parameter int NUM_CIR = 11,
    parameter int NUM_ALC = 4
) (
    input  logic        cyc_valid,
    input  logic [2:0]  fc,
    input  logic [19:0] addr,
    output dec_t        dec
);

    logic       cpu_cyc;
    logic [3:0] cyc_type;
    logic [2:0] cp_id;
    logic [3:0] widx;
    logic       unused_a0;

    assign unused_a0 = addr[0];

    always_comb begin
        cyc_type = addr[19:16];
        cp_id    = addr[15:13];
        widx     = addr[4:1];
        cpu_cyc  = cyc_valid && (fc == FC_CPU) && (addr[12:5] == 8'd0);

        dec          = '0;
        dec.word_idx = widx;
        dec.bkpt_idx = addr[4:2];
        dec.is_copro = cpu_cyc && (cyc_type == TYPE_COPRO) && (cp_id == COPRO_ID)
                       && (32'(widx) < NUM_CIR);
        dec.is_alc   = cpu_cyc && (cyc_type == TYPE_ALC) && (32'(widx) < NUM_ALC);
        dec.is_bkpt  = cpu_cyc && (cyc_type == TYPE_BKPT);
    end

endmodule

// File: rtl/bkpt_bank.sv
module bkpt_bank
    import cpu_space_pkg::*;
#(
    parameter int NUM_BKPT = 8,
    parameter int OPC_W    = 16,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = $clog2(NUM_BKPT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic [IDX_W-1:0] idx,
    input  logic             cfg_we,
    input  logic             cfg_ctrl,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [OPC_W-1:0] cfg_wdata,
    output rsp_kind_e        kind_o,
    output logic [OPC_W-1:0] opcode_o
);

    typedef struct packed {
        logic [NUM_BKPT-1:0]            en;
        logic [NUM_BKPT-1:0][CNT_W-1:0] cnt;
        logic [NUM_BKPT-1:0][OPC_W-1:0] opc;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d     = bk_q;
        kind_o   = RSP_BUSERR;
        opcode_o = '0;
        if (bk_q.en[idx]) begin
            if (bk_q.cnt[idx] != '0) begin
                kind_o = RSP_ILLEGAL;
                if (ack) begin
                    bk_d.cnt[idx] = bk_q.cnt[idx] - CNT_W'(1);
                end
            end else begin
                kind_o   = RSP_OPCODE;
                opcode_o = bk_q.opc[idx];
            end
        end
        if (cfg_we) begin
            if (cfg_ctrl) begin
                bk_d.en[cfg_idx]  = cfg_wdata[OPC_W-1];
                bk_d.cnt[cfg_idx] = cfg_wdata[CNT_W-1:0];
            end else begin
                bk_d.opc[cfg_idx] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    // R7: an acknowledged, enabled, counting breakpoint loses exactly one count
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && bk_q.en[idx] && (bk_q.cnt[idx] != '0) && !(cfg_we && cfg_idx == idx))
        |=> (bk_q.cnt[$past(idx)] == $past(bk_q.cnt[idx]) - CNT_W'(1)));

    // R8: a disabled breakpoint is left untouched by its acknowledge
    assert_disabled_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !bk_q.en[idx] && !cfg_we) |=> ($stable(bk_q.cnt) && $stable(bk_q.en)));

    // R6: an expired count stays at zero while the opcode is returned
    assert_expired_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && bk_q.en[idx] && (bk_q.cnt[idx] == '0) && !cfg_we)
        |=> (bk_q.cnt[$past(idx)] == '0));

endmodule

// File: rtl/cpu_space_decoder.sv
module cpu_space_decoder
    import cpu_space_pkg::*;
#(
    parameter int NUM_CIR  = 11,
    parameter int NUM_ALC  = 4,
    parameter int NUM_BKPT = 8,
    parameter int OPC_W    = 16,
    parameter int CNT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cyc_valid,
    input  logic [2:0]                  fc,
    input  logic [19:0]                 addr,
    input  logic                        cfg_we,
    input  logic                        cfg_ctrl,
    input  logic [$clog2(NUM_BKPT)-1:0] cfg_idx,
    input  logic [OPC_W-1:0]            cfg_wdata,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_kind,
    output logic [OPC_W-1:0]            rsp_data,
    output logic [NUM_CIR-1:0]          cir_sel,
    output logic [NUM_ALC-1:0]          alc_sel
);

    localparam int IDX_W = $clog2(NUM_BKPT);

    typedef struct packed {
        logic               valid;
        logic [1:0]         kind;
        logic [OPC_W-1:0]   data;
        logic [NUM_CIR-1:0] cir;
        logic [NUM_ALC-1:0] alc;
    } out_t;

    dec_t               dec;
    rsp_kind_e          bk_kind;
    logic [OPC_W-1:0]   bk_opc;
    logic [NUM_CIR-1:0] cir_hit;
    logic [NUM_ALC-1:0] alc_hit;
    out_t               out_d, out_q;

    cs_addr_decode #(
        .NUM_CIR (NUM_CIR),
        .NUM_ALC (NUM_ALC)
    ) u_dec (
        .cyc_valid (cyc_valid),
        .fc        (fc),
        .addr      (addr),
        .dec       (dec)
    );

    bkpt_bank #(
        .NUM_BKPT (NUM_BKPT),
        .OPC_W    (OPC_W),
        .CNT_W    (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (dec.is_bkpt),
        .idx       (dec.bkpt_idx[IDX_W-1:0]),
        .cfg_we    (cfg_we),
        .cfg_ctrl  (cfg_ctrl),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .kind_o    (bk_kind),
        .opcode_o  (bk_opc)
    );

    for (genvar g = 0; g < NUM_CIR; g++) begin : g_cir
        assign cir_hit[g] = dec.is_copro && (32'(dec.word_idx) == g);
    end

    for (genvar g = 0; g < NUM_ALC; g++) begin : g_alc
        assign alc_hit[g] = dec.is_alc && (32'(dec.word_idx) == g);
    end

    always_comb begin
        out_d     = '0;
        out_d.cir = cir_hit;
        out_d.alc = alc_hit;
        if (dec.is_copro || dec.is_alc) begin
            out_d.valid = 1'b1;
            out_d.kind  = RSP_REGSEL;
        end
        if (dec.is_bkpt) begin
            out_d.valid = 1'b1;
            out_d.kind  = bk_kind;
            out_d.data  = bk_opc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rsp_valid = out_q.valid;
    assign rsp_kind  = out_q.kind;
    assign rsp_data  = out_q.data;
    assign cir_sel   = out_q.cir;
    assign alc_sel   = out_q.alc;

    // R12: a response only follows a presented cycle
    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cyc_valid));

    // R1: cycles outside CPU space are never answered
    assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && fc != FC_CPU) |=> !rsp_valid);

    // R3: a foreign coprocessor identifier gets no answer
    assert_copro_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && fc == FC_CPU && addr[19:16] == TYPE_COPRO && addr[15:13] != COPRO_ID)
        |=> !rsp_valid);

    // R2: at most one register select per response
    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cir_sel, alc_sel}));

endmodule

// File: tb/sim_cpu_space_decoder.sv
module sim_cpu_space_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [2:0]  fc = 3'd0;
    logic [19:0] addr = 20'd0;
    logic        cfg_we = 1'b0;
    logic        cfg_ctrl = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [15:0] rsp_data;
    logic [10:0] cir_sel;
    logic [3:0]  alc_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit        m_en  [8];
    int        m_cnt [8];
    bit [15:0] m_opc [8];

    // expected outputs for the next sampling point
    bit        e_valid = 0;
    bit [1:0]  e_kind = 0;
    bit [15:0] e_data = 0;
    bit [10:0] e_cir = 0;
    bit [3:0]  e_alc = 0;
    string     e_tag = "R10";

    always #10 clk = ~clk;

    cpu_space_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .fc        (fc),
        .addr      (addr),
        .cfg_we    (cfg_we),
        .cfg_ctrl  (cfg_ctrl),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .rsp_valid (rsp_valid),
        .rsp_kind  (rsp_kind),
        .rsp_data  (rsp_data),
        .cir_sel   (cir_sel),
        .alc_sel   (alc_sel)
    );

    function automatic logic [19:0] mk(input int typ, input int id, input int low);
        return {typ[3:0], id[2:0], 8'd0, low[4:0]};
    endfunction

    task automatic compare();
        checks++;
        if (rsp_valid !== e_valid || rsp_kind !== e_kind || rsp_data !== e_data ||
            cir_sel !== e_cir || alc_sel !== e_alc) begin
            errors++;
            $display("FAIL %s: actual v=%0b k=%0d d=%h cir=%b alc=%b expected v=%0b k=%0d d=%h cir=%b alc=%b",
                     e_tag, rsp_valid, rsp_kind, rsp_data, cir_sel, alc_sel,
                     e_valid, e_kind, e_data, e_cir, e_alc);
        end
    endtask

    // compare previous result, then drive a new cycle and advance the model
    task automatic tick(input bit cv, input int f, input logic [19:0] a,
                        input bit we, input bit ctl, input int ci, input int wd,
                        input string tag);
        int n;
        @(negedge clk);
        compare();
        cyc_valid = cv; fc = f[2:0]; addr = a;
        cfg_we = we; cfg_ctrl = ctl; cfg_idx = ci[2:0]; cfg_wdata = wd[15:0];
        e_valid = 0; e_kind = 0; e_data = 0; e_cir = 0; e_alc = 0; e_tag = tag;
        if (cv && f == 7 && a[12:5] == 0) begin
            if (a[19:16] == 2 && a[15:13] == 0 && a[4:1] < 11) begin
                e_valid = 1; e_cir = 11'(1) << a[4:1];
            end else if (a[19:16] == 1 && a[4:1] < 4) begin
                e_valid = 1; e_alc = 4'(1) << a[4:1];
            end else if (a[19:16] == 0) begin
                n = int'(a[4:2]);
                e_valid = 1;
                if (!m_en[n]) e_kind = 3;
                else if (m_cnt[n] != 0) begin e_kind = 2; m_cnt[n]--; end
                else begin e_kind = 1; e_data = m_opc[n]; end
            end
        end
        if (we) begin
            if (ctl) begin m_en[ci] = wd[15]; m_cnt[ci] = wd & 8'hFF; end
            else m_opc[ci] = wd[15:0];
        end
    endtask

    task automatic idle(input string tag);
        tick(0, 0, 20'd0, 0, 0, 0, 0, tag);
    endtask

    task automatic bk(input int n, input string tag);
        tick(1, 7, mk(0, 0, n << 2), 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit ctl, input int n, input int wd, input string tag);
        tick(0, 0, 20'd0, 1, ctl, n, wd, tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_cnt[i] = 0; m_opc[i] = 0; end
        repeat (4) @(negedge clk);
        // R10: outputs held at zero during reset
        compare();
        rst_n = 1'b1;
        idle("R10");
        bk(3, "R10");             // reset leaves breakpoints disabled
        idle("R10");
        for (int i = 0; i < 8; i++) wr(0, i, 16'hA000 + i * 16'h0111, "R11");
        wr(1, 0, 16'h8000, "R11");
        wr(1, 1, 16'h8002, "R11");
        wr(1, 2, 16'h0005, "R11");
        wr(1, 7, 16'h8000, "R11");
        wr(1, 3, 16'h8001, "R11");
        bk(0, "R6");
        bk(7, "R6");
        bk(0, "R6");
        bk(1, "R7");
        bk(1, "R7");
        bk(1, "R7");
        bk(1, "R6");
        bk(2, "R8");
        bk(2, "R8");
        wr(1, 2, 16'h8005, "R11");
        bk(2, "R8");              // enabled now: count 5 kept -> illegal
        // R1: non-CPU-space cycle aimed at breakpoint 3
        tick(1, 2, mk(0, 0, 3 << 2), 0, 0, 0, 0, "R1");
        tick(1, 5, mk(2, 0, 2), 0, 0, 0, 0, "R1");
        bk(3, "R1");
        bk(3, "R1");
        // R2: every interface register, back to back (R12)
        for (int i = 0; i < 11; i++) tick(1, 7, mk(2, 0, i << 1), 0, 0, 0, 0, "R2");
        idle("R12");
        tick(1, 7, mk(2, 0, 11 << 1), 0, 0, 0, 0, "R4");
        tick(1, 7, mk(2, 0, 15 << 1), 0, 0, 0, 0, "R4");
        tick(1, 7, mk(2, 3, 2), 0, 0, 0, 0, "R3");
        tick(1, 7, mk(2, 7, 0), 0, 0, 0, 0, "R3");
        for (int i = 0; i < 5; i++) tick(1, 7, mk(1, 0, i << 1), 0, 0, 0, 0, "R5");
        tick(1, 7, mk(5, 0, 0), 0, 0, 0, 0, "R9");
        tick(1, 7, mk(15, 0, 0), 0, 0, 0, 0, "R9");
        tick(1, 7, mk(2, 0, 2) | 20'h00040, 0, 0, 0, 0, "R9");
        tick(1, 7, mk(0, 0, 0) | 20'h01000, 0, 0, 0, 0, "R9");
        // R11: write to a disabled breakpoint in the same clock as its acknowledge
        tick(1, 7, mk(0, 0, 4 << 2), 1, 1, 4, 16'h8001, "R11");
        bk(4, "R11");
        bk(4, "R11");
        // R11: rewrite replaces the count step
        wr(1, 5, 16'h8001, "R11");
        tick(1, 7, mk(0, 0, 5 << 2), 1, 1, 5, 16'h8002, "R11");
        bk(5, "R11");
        bk(5, "R11");
        bk(5, "R11");
        wr(0, 5, 16'h1234, "R11");
        bk(5, "R11");
        idle("R12");
        idle("R12");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule